// File: doc/BRIEF.md
# Interrupt Source Configuration and Routing

This block holds a bank of interrupt sources and turns their raw input lines into per-processor request vectors. Every source owns two software registers. The first is a configuration word with a mask, a priority, a vector number, a trigger-sense bit, a polarity bit and a flag that steers the source to the critical output. The second is a destination word, which is a bitmap of target processors. Each source belongs to a fixed class: external, internal, timer or inter-processor. The class is set by a parameter, and it decides which configuration bits exist and whether the source is level- or edge-triggered.

The block does not choose a winner. For every processor it presents the set of sources that currently request it, and for every source it presents the priority and vector. A downstream arbiter picks the winner and returns an acknowledge. Sources routed to the critical output skip that path completely. They drive a per-processor critical line that is not ranked by priority and not affected by acknowledges. A parameter selects the older compatibility behaviour, in which critical sources also ignore their mask.

Top module: `irq_route`

## Requirements
- R1: After reset every source is masked (config bit 31 set), every other field is zero, and every request and critical output is low.
- R2: The configuration word reads back as follows. Bit 31 is the mask. Bit 30 is the read-only active state. Bit 29 is the critical route. Bit 23 is polarity. Bit 22 is sense (1 = level). Bits 19:16 are the 4-bit priority. The low VEC_W bits are the vector. All other bits read as zero. The priority and vector of each source also appear on `src_prio` and `src_vec`.
- R3: On internal sources the sense bit reads as zero, but the source still behaves as level-triggered. On timer and inter-processor sources both the sense and polarity bits read as zero.
- R4: A level source requests in the cycle after its input is sampled high while it is unmasked. The request is withdrawn in the cycle after the input is sampled low, or once the mask is set.
- R5: An edge source (external with sense 0, timer, inter-processor) latches a pending state on a rising input, even while masked, and holds it after the input falls. An acknowledge naming the source clears the latch. If a new rising edge arrives in the same cycle as the acknowledge, the latch stays set.
- R6: Polarity is only stored. A level source with polarity 1 still requests while its input is high.
- R7: Request bit `cpu_req[c*NUM_SRC+i]` is raised only when destination bit c of source i is set. Destination bits at and above NUM_CPU read as zero.
- R8: A critical-routed source never appears in `cpu_req`. It drives `crit_out` on every destination processor while it is active and unmasked, and an acknowledge has no effect on it.
- R9: With LEGACY_CRIT set, a critical-routed source drives `crit_out` even while masked.
- R10: Writing a configuration word with bit 31 set clears that source's edge latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NUM_SRC | Raw interrupt input lines, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Bit 0 selects config (0) or destination (1); upper bits give the source index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| ack_valid | input | 1 | Acknowledge from the arbiter |
| ack_src | input | ADDR_W-1 | Index of the acknowledged source |
| cpu_req | output | NUM_CPU*NUM_SRC | Request bit for each processor and source pair, processor-major |
| src_prio | output | 4*NUM_SRC | Priority of each source |
| src_vec | output | VEC_W*NUM_SRC | Vector of each source |
| crit_out | output | NUM_CPU | Critical interrupt line for each processor |

## Verification
Two events can land on one edge source in the same cycle: an acknowledge that clears its latch and a fresh rising edge that sets it. The bench first latches a pulse. It then raises the input again in the exact cycle it presents the acknowledge. The request must still be present afterwards, and a second acknowledge with the input low must clear it. A behavioural model in the bench predicts every output on every cycle. That model covers the other overlaps as well, such as a masking write that lands together with a level withdrawal.

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NUM_SRC = 8,
  parameter int NUM_CPU = 4,
  parameter int VEC_W = 8,
  parameter logic [2*NUM_SRC-1:0] SRC_CLASS = 16'hE500,
  parameter bit LEGACY_CRIT = 1'b0,
  localparam int IDX_W = $clog2(NUM_SRC),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         src_in,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  input  logic                       ack_valid,
  input  logic [IDX_W-1:0]           ack_src,
  output logic [NUM_CPU*NUM_SRC-1:0] cpu_req,
  output logic [4*NUM_SRC-1:0]       src_prio,
  output logic [VEC_W*NUM_SRC-1:0]   src_vec,
  output logic [NUM_CPU-1:0]         crit_out
);

  logic [NUM_SRC-1:0] msk, crt, sns, pol, src_q, pend, pend_n;
  logic [NUM_SRC-1:0] lvl, act, clr, vpr_we, dst_we, sns_ok, pol_ok;
  logic [NUM_SRC-1:0][3:0] pri;
  logic [NUM_SRC-1:0][VEC_W-1:0] vec;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] dst;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] crit_mat;
  logic [IDX_W-1:0] ridx;
  logic unused_bits;

  assign ridx = addr[ADDR_W-1:1];
  assign unused_bits = ^{wdata[28:24], wdata[21:20], wdata[15:VEC_W]};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [1:0] CL = SRC_CLASS[2*i +: 2];
    logic sel;
    assign sel       = (ridx == IDX_W'(i));
    assign sns_ok[i] = (CL == 2'd0);
    assign pol_ok[i] = (CL <= 2'd1);
    assign lvl[i]    = (CL == 2'd1) | (sns_ok[i] & sns[i]);
    assign vpr_we[i] = wr_en & ~addr[0] & sel;
    assign dst_we[i] = wr_en & addr[0] & sel;
    assign clr[i]    = (ack_valid && ack_src == IDX_W'(i) && !crt[i]) || (vpr_we[i] && wdata[31]);
    assign pend_n[i] = ~lvl[i] & ((src_in[i] & ~src_q[i]) | (pend[i] & ~clr[i]));
    assign act[i]    = lvl[i] ? src_q[i] : pend[i];
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      assign cpu_req[c*NUM_SRC+i] = act[i] & ~msk[i] & ~crt[i] & dst[i][c];
      assign crit_mat[c][i] = act[i] & crt[i] & (LEGACY_CRIT | ~msk[i]) & dst[i][c];
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_crit
    assign crit_out[c] = |crit_mat[c];
  end

  assign src_prio = pri;
  assign src_vec  = vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      msk <= '1; crt <= '0; sns <= '0; pol <= '0;
      pri <= '0; vec <= '0; dst <= '0;
      src_q <= '0; pend <= '0;
    end else begin
      src_q <= src_in;
      pend  <= pend_n;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (vpr_we[i]) begin
          msk[i] <= wdata[31];
          crt[i] <= wdata[29];
          sns[i] <= sns_ok[i] & wdata[22];
          pol[i] <= pol_ok[i] & wdata[23];
          pri[i] <= wdata[19:16];
          vec[i] <= wdata[VEC_W-1:0];
        end
        if (dst_we[i]) dst[i] <= wdata[NUM_CPU-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr[0]) begin
      rdata[31]         = msk[ridx];
      rdata[30]         = act[ridx];
      rdata[29]         = crt[ridx];
      rdata[23]         = pol[ridx];
      rdata[22]         = sns[ridx];
      rdata[19:16]      = pri[ridx];
      rdata[VEC_W-1:0]  = vec[ridx];
    end else begin
      rdata[NUM_CPU-1:0] = dst[ridx];
    end
  end

endmodule

module irq_route_chk #(
  parameter int NUM_SRC = 8,
  parameter int NUM_CPU = 4,
  parameter logic [2*NUM_SRC-1:0] SRC_CLASS = 16'hE500
) (
  input logic                              clk,
  input logic                              rst,
  input logic [NUM_SRC-1:0]                src_in,
  input logic                              ack_valid,
  input logic                              wr_en,
  input logic [NUM_CPU*NUM_SRC-1:0]        cpu_req,
  input logic [NUM_CPU-1:0]                crit_out,
  input logic [NUM_SRC-1:0]                act,
  input logic [NUM_SRC-1:0]                crt,
  input logic [NUM_SRC-1:0]                msk,
  input logic [NUM_SRC-1:0][NUM_CPU-1:0]   dst
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (cpu_req == '0 && crit_out == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_s
    localparam logic [1:0] CL = SRC_CLASS[2*i +: 2];
    logic [NUM_CPU-1:0] req_of;
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
      assign req_of[c] = cpu_req[c*NUM_SRC+i];
    end

    // R8
    crit_excl_chk: assert property (@(posedge clk) disable iff (rst) crt[i] |-> req_of == '0);

    // R7
    route_chk: assert property (@(posedge clk) disable iff (rst) (req_of & ~dst[i]) == '0);

    // R4
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst) msk[i] |-> req_of == '0);

    if (CL == 2'd1) begin : g_lvl
      // R4
      lvl_drop_chk: assert property (@(posedge clk) disable iff (rst) !src_in[i] |=> !act[i]);
    end
    if (CL >= 2'd2) begin : g_edge
      // R5
      edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        act[i] && !ack_valid && !wr_en |=> act[i]);
    end
  end

endmodule

bind irq_route irq_route_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .SRC_CLASS(SRC_CLASS)) u_chk (
  .clk(clk), .rst(rst), .src_in(src_in), .ack_valid(ack_valid), .wr_en(wr_en),
  .cpu_req(cpu_req), .crit_out(crit_out), .act(act), .crt(crt), .msk(msk), .dst(dst)
);

// File: tb/irq_route_bench.sv
`timescale 1ns/1ps
module irq_route_bench;
  localparam int NS = 8, NC = 4, VW = 8, AW = 4;

  logic clk = 0, rst = 1;
  logic [NS-1:0] src_in = '0;
  logic wr_en = 0, ack_valid = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0] ack_src = '0;
  logic [31:0] rdata, l_rdata;
  logic [NS*NC-1:0] cpu_req, l_cpu_req;
  logic [4*NS-1:0] src_prio, l_prio;
  logic [VW*NS-1:0] src_vec, l_vec;
  logic [NC-1:0] crit_out, l_crit;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_route u_irq_route (.clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ack_valid(ack_valid), .ack_src(ack_src),
    .cpu_req(cpu_req), .src_prio(src_prio), .src_vec(src_vec), .crit_out(crit_out));

  irq_route #(.LEGACY_CRIT(1'b1)) u_irq_route_legacy (.clk(clk), .rst(rst), .src_in(src_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(l_rdata), .ack_valid(ack_valid),
    .ack_src(ack_src), .cpu_req(l_cpu_req), .src_prio(l_prio), .src_vec(l_vec), .crit_out(l_crit));

  bit m_msk[NS], m_crt[NS], m_sns[NS], m_pol[NS], m_q[NS], m_pend[NS];
  int m_pri[NS], m_vec[NS], m_dst[NS];

  function automatic int cls(int i);
    return (i < 4) ? 0 : (i < 6) ? 1 : (i == 6) ? 2 : 3;
  endfunction
  function automatic bit is_lvl(int i);
    return (cls(i) == 0) ? m_sns[i] : (cls(i) == 1);
  endfunction
  function automatic bit is_act(int i);
    return is_lvl(i) ? m_q[i] : m_pend[i];
  endfunction

  always @(posedge clk) begin : model
    bit np[NS];
    if (rst) begin
      for (int i = 0; i < NS; i++) begin
        m_msk[i] = 1; m_crt[i] = 0; m_sns[i] = 0; m_pol[i] = 0; m_q[i] = 0; m_pend[i] = 0;
        m_pri[i] = 0; m_vec[i] = 0; m_dst[i] = 0;
      end
    end else begin
      for (int i = 0; i < NS; i++) begin
        bit rise, clr;
        rise = src_in[i] && !m_q[i];
        clr = (ack_valid && ack_src == i && !m_crt[i]) ||
              (wr_en && !addr[0] && addr[3:1] == i && wdata[31]);
        np[i] = !is_lvl(i) && (rise || (m_pend[i] && !clr));
      end
      for (int i = 0; i < NS; i++) begin
        m_pend[i] = np[i];
        m_q[i] = src_in[i];
      end
      if (wr_en) begin
        int k;
        k = addr[3:1];
        if (!addr[0]) begin
          m_msk[k] = wdata[31]; m_crt[k] = wdata[29];
          m_sns[k] = (cls(k) == 0) ? wdata[22] : 0;
          m_pol[k] = (cls(k) <= 1) ? wdata[23] : 0;
          m_pri[k] = wdata[19:16]; m_vec[k] = wdata[7:0];
        end else m_dst[k] = wdata[3:0];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin : compare
    if (!rst && !done) begin
      logic [NS*NC-1:0] er;
      logic [NC-1:0] ec, el;
      logic [31:0] ed;
      int k;
      er = '0; ec = '0; el = '0;
      for (int i = 0; i < NS; i++)
        for (int c = 0; c < NC; c++) begin
          bit hit;
          hit = is_act(i) && m_dst[i][c];
          if (hit && !m_msk[i] && !m_crt[i]) er[c*NS+i] = 1;
          if (hit && m_crt[i] && !m_msk[i]) ec[c] = 1;
          if (hit && m_crt[i]) el[c] = 1;
        end
      k = addr[3:1];
      ed = '0;
      if (!addr[0]) begin
        ed[31] = m_msk[k]; ed[30] = is_act(k); ed[29] = m_crt[k]; ed[23] = m_pol[k];
        ed[22] = m_sns[k]; ed[19:16] = m_pri[k][3:0]; ed[7:0] = m_vec[k][7:0];
      end else ed[3:0] = m_dst[k][3:0];
      chk("cycle R4 R5 R7 cpu_req", cpu_req, er);
      chk("cycle R8 crit_out", {28'b0, crit_out}, {28'b0, ec});
      chk("cycle R9 legacy crit_out", {28'b0, l_crit}, {28'b0, el});
      chk("cycle R2 rdata", rdata, ed);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask
  task automatic wr(int a, logic [31:0] d);
    wr_en = 1; addr = AW'(a); wdata = d; step(); wr_en = 0;
  endtask
  task automatic ack(int s);
    ack_valid = 1; ack_src = 3'(s); step(); ack_valid = 0;
  endtask
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step(3); rst = 0; step();
    // R1 reset state
    addr = 0; #0; chk("R1 config after reset", rdata, 32'h8000_0000);
    chk("R1 cpu_req after reset", cpu_req, 0);
    chk("R1 crit_out after reset", {28'b0, crit_out}, 0);

    // R4 level source 0, R2 fields
    wr(0, 32'h0045_0021); wr(1, 32'h2);
    src_in[0] = 1; step();
    chk("R4 level request", cpu_req[1*NS+0], 1);
    chk("R2 prio out", src_prio[3:0], 5);
    chk("R2 vec out", src_vec[7:0], 8'h21);
    wr(0, 32'h8045_0021);
    chk("R4 mask withdraws", cpu_req[1*NS+0], 0);
    wr(0, 32'h0045_0021);
    chk("R4 unmask restores", cpu_req[1*NS+0], 1);
    src_in[0] = 0; step();
    chk("R4 deassert withdraws", cpu_req[1*NS+0], 0);
    addr = 0; #0; chk("R2 readback", rdata, 32'h0045_0021);

    // R5 edge source 1, R7 routing
    wr(2, 32'h0003_0011); wr(3, 32'h5);
    src_in[1] = 1; step(); src_in[1] = 0; step();
    chk("R5 edge latched cpu0", cpu_req[0*NS+1], 1);
    chk("R7 edge routed cpu2", cpu_req[2*NS+1], 1);
    chk("R7 not routed cpu1", cpu_req[1*NS+1], 0);
    ack(1);
    chk("R5 ack clears", cpu_req[0*NS+1], 0);
    src_in[1] = 1; step(); src_in[1] = 0; step();
    src_in[1] = 1; ack(1);
    chk("R5 rise with ack keeps", cpu_req[0*NS+1], 1);
    src_in[1] = 0; ack(1);
    chk("R5 second ack clears", cpu_req[0*NS+1], 0);

    // R3 internal source 4
    wr(8, 32'h00C2_0044);
    addr = 8; #0; chk("R3 internal sense reads zero", rdata, 32'h0082_0044);
    wr(9, 32'h1);
    src_in[4] = 1; step();
    chk("R3 internal acts level", cpu_req[4], 1);
    src_in[4] = 0; step();
    chk("R4 internal withdraw", cpu_req[4], 0);

    // R3 timer source 6
    wr(12, 32'h00C1_0066);
    addr = 12; #0; chk("R3 timer sense/pol zero", rdata, 32'h0001_0066);
    wr(13, 32'h8);
    src_in[6] = 1; step(); src_in[6] = 0; step(2);
    chk("R5 timer edge held", cpu_req[3*NS+6], 1);
    ack(6);
    chk("R5 timer ack", cpu_req[3*NS+6], 0);

    // R6 polarity storage only
    wr(4, 32'h00C4_0002); wr(5, 32'h1);
    src_in[2] = 1; step();
    chk("R6 polarity no effect", cpu_req[2], 1);
    src_in[2] = 0; step();
    chk("R6 low input idle", cpu_req[2], 0);

    // R7 destination width
    wr(5, 32'hFFFF_FFFF);
    addr = 5; #0; chk("R7 dest readback", rdata, 32'h0000_000F);

    // R8/R9 critical edge source 3, R10
    wr(6, 32'hA000_0003); wr(7, 32'h8);
    src_in[3] = 1; step(); src_in[3] = 0; step();
    chk("R8 masked crit off", {28'b0, crit_out}, 0);
    chk("R9 legacy ignores mask", {28'b0, l_crit}, 32'h8);
    wr(6, 32'h2000_0003);
    chk("R8 crit drives cpu3", {28'b0, crit_out}, 32'h8);
    chk("R8 crit not in cpu_req", cpu_req[3*NS+3], 0);
    ack(3);
    chk("R8 ack ignored", {28'b0, crit_out}, 32'h8);
    wr(6, 32'hA000_0003);
    chk("R10 mask write clears", {28'b0, l_crit}, 0);

    // R5 latch while masked, R10 on IPI source 7
    wr(14, 32'h8000_0077); wr(15, 32'h1);
    src_in[7] = 1; step(); src_in[7] = 0; step();
    chk("R5 masked no request", cpu_req[7], 0);
    wr(14, 32'h0000_0077);
    chk("R5 latched while masked", cpu_req[7], 1);
    wr(14, 32'h8000_0077); wr(14, 32'h0000_0077);
    chk("R10 latch cleared", cpu_req[7], 0);

    step(2);
    finish_run();
  end
endmodule